// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execution Unit

This unit runs the second byte of a two-byte bit-manipulation instruction in an 8-bit CPU core. On a start strobe it latches the opcode byte, the incoming flags and the memory pointer held in the HL pair. It splits the byte into an operation group, a sub-operation or bit number, and an operand selector. Then it fetches the operand from the core's eight-entry register file or from memory. It produces a rotated, shifted, nibble-swapped, bit-tested, bit-cleared or bit-set value together with new Z, N, H and C flags.

The register file and the memory are outside the unit. The unit drives a read selector and takes back read data combinationally from the register file. It issues single-clock read and write strobes to memory. The memory returns read data one clock after the read strobe. The unit paces itself in machine cycles of a fixed number of clock ticks, so the core sees the same instruction cost on every run. The last clock of the operation carries a single done pulse.

Top module: `cb_bitop_unit`

## Requirements
- R1: Opcode bits 2:0 choose the operand: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 the byte in memory at HL, 7 A. The register number appears on `rf_rd_sel` and `rf_wr_sel`. Bits 7:6 choose the group: 00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set. For the test, clear and set groups, bits 5:3 give the bit number.
- R2: Within group 00, bits 5:3 pick the rotate. 0 is a circular left rotate and 1 is a circular right rotate; the bit that leaves one end re-enters at the other. 2 rotates left through carry and 3 rotates right through carry; the old C enters the vacated end.
- R3: Sub-operation 4 shifts left and 7 shifts right, both filling with zero. Sub-operation 5 shifts right and keeps bit 7 as it was.
- R4: For the rotates and shifts, the bit pushed out goes to C, N and H become 0, and Z is 1 exactly when the 8-bit result is zero. Flags use `flags_in`/`flags_out` bit 3 = Z, 2 = N, 1 = H, 0 = C.
- R5: Sub-operation 6 exchanges the high and low nibbles, clears N, H and C, and sets Z from the result.
- R6: A bit test sets Z to the inverse of the chosen bit, clears N, sets H, keeps C, and writes nothing to the register file or memory.
- R7: Bit clear and bit set change only the chosen bit and return `flags_out` equal to the `flags_in` captured at start.
- R8: Counting from the clock after start is taken, `done` is high on clock 8 for a register operand and on clock 16 for the memory operand (2 and 4 machine cycles of 4 ticks).
- R9: A memory operand makes exactly one read strobe and, unless it is a bit test, exactly one write strobe, both with `mem_addr` equal to the HL value latched at start. Read data is expected on `mem_rdata` the clock after `mem_rd_en`.
- R10: `done` is high for exactly one clock per operation. A register write-back (`rf_wr_en`) happens only in that clock.
- R11: A start that arrives while an operation is in progress is ignored: it causes no extra done pulse and no register change.
- R12: After reset, `done`, `rf_wr_en`, `mem_rd_en`, `mem_wr_en` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with `opcode` (taken only when idle) |
| opcode | input | 8 | Second instruction byte |
| flags_in | input | 4 | Current Z,N,H,C flags |
| hl_addr | input | ADDR_W | HL pair, memory operand address |
| rf_rd_sel | output | 3 | Register file read selector |
| rf_rd_data | input | 8 | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_sel | output | 3 | Register file write selector |
| rf_wr_data | output | 8 | Register file write data |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one clock after the read strobe |
| flags_out | output | 4 | Updated Z,N,H,C flags, valid from the done clock |
| done | output | 1 | One-clock completion pulse |

## Verification
The hardest condition to reach from the ports is a start strobe that lands partway through a running operation. The bench raises a second start with a different opcode three clocks into a register rotate. It then counts done pulses over a long window and reads back both target registers through its register-file model, which shows that the intruding opcode never ran. The memory read-modify-write path is second in difficulty. A memory model in the bench counts strobes and records the write address, so the bench can tell a skipped write on a bit test from one sent to the wrong address.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int DW = 8;
  localparam int SEL_W = 3;
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;
  localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    SH_RLC  = 3'd0,
    SH_RRC  = 3'd1,
    SH_RL   = 3'd2,
    SH_RR   = 3'd3,
    SH_SLA  = 3'd4,
    SH_SRA  = 3'd5,
    SH_SWAP = 3'd6,
    SH_SRL  = 3'd7
  } shop_e;

  typedef struct packed {
    grp_e             grp;
    logic [2:0]       sub;
    logic [SEL_W-1:0] sel;
    logic             is_mem;
    logic             is_test;
  } dec_t;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
(
  input  logic [7:0] opc,
  output dec_t       dec
);
  always_comb begin
    dec.grp     = grp_e'(opc[7:6]);
    dec.sub     = opc[5:3];
    dec.sel     = opc[2:0];
    dec.is_mem  = (opc[2:0] == SEL_MEM);
    dec.is_test = (opc[7:6] == 2'b01);
  end
endmodule

// File: rtl/cbu_alu.sv
module cbu_alu
  import cbu_pkg::*;
(
  input  dec_t          dec,
  input  logic [DW-1:0] a,
  input  logic [3:0]    fin,
  output logic [DW-1:0] res,
  output logic [3:0]    fout
);
  localparam int HW = DW / 2;

  logic [DW-1:0] bit_mask;
  logic          cin;
  logic [DW-1:0] sh_res;
  logic          sh_c;

  // one-hot mask of the addressed bit
  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign bit_mask[i] = (dec.sub == 3'(i));
  end

  assign cin = fin[FC];

  always_comb begin
    sh_res = a;
    sh_c   = 1'b0;
    case (shop_e'(dec.sub))
      SH_RLC:  begin sh_res = {a[DW-2:0], a[DW-1]}; sh_c = a[DW-1]; end
      SH_RRC:  begin sh_res = {a[0], a[DW-1:1]};    sh_c = a[0];    end
      SH_RL:   begin sh_res = {a[DW-2:0], cin};     sh_c = a[DW-1]; end
      SH_RR:   begin sh_res = {cin, a[DW-1:1]};     sh_c = a[0];    end
      SH_SLA:  begin sh_res = {a[DW-2:0], 1'b0};    sh_c = a[DW-1]; end
      SH_SRA:  begin sh_res = {a[DW-1], a[DW-1:1]}; sh_c = a[0];    end
      SH_SWAP: begin sh_res = {a[HW-1:0], a[DW-1:HW]}; sh_c = 1'b0; end
      SH_SRL:  begin sh_res = {1'b0, a[DW-1:1]};    sh_c = a[0];    end
      default: begin sh_res = a; sh_c = 1'b0; end
    endcase
  end

  always_comb begin
    res  = a;
    fout = fin;
    case (dec.grp)
      GRP_SHIFT: begin
        res      = sh_res;
        fout[FZ] = (sh_res == '0);
        fout[FN] = 1'b0;
        fout[FH] = 1'b0;
        fout[FC] = sh_c;
      end
      GRP_TEST: begin
        res      = a;
        fout[FZ] = ((a & bit_mask) == '0);
        fout[FN] = 1'b0;
        fout[FH] = 1'b1;
      end
      GRP_CLR: res = a & ~bit_mask;
      GRP_SET: res = a | bit_mask;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/cbu_ctrl.sv
module cbu_ctrl #(
  parameter int TICKS  = 4,
  parameter int REG_MC = 2,
  parameter int MEM_MC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_mem,
  input  logic is_test,
  output logic busy,
  output logic accept,
  output logic cap_reg,
  output logic cap_mem,
  output logic load_out,
  output logic mem_rd_en,
  output logic mem_wr_en,
  output logic rf_wr_en,
  output logic done
);
  localparam int LAST_REG = REG_MC * TICKS - 1;
  localparam int LAST_MEM = MEM_MC * TICKS - 1;
  localparam int RD_T     = TICKS;
  localparam int CAP_T    = TICKS + 1;
  localparam int WR_T     = (MEM_MC - 1) * TICKS;
  localparam int CW       = $clog2(LAST_MEM + 1);

  logic [CW-1:0] tick_q, nxt, last;
  logic          busy_q, rd_q, wr_q, rfw_q, done_q;

  assign nxt      = tick_q + CW'(1);
  assign last     = is_mem ? CW'(LAST_MEM) : CW'(LAST_REG);
  assign accept   = !busy_q && start;
  assign cap_reg  = busy_q && !is_mem && (tick_q == '0);
  assign cap_mem  = busy_q && is_mem && (tick_q == CW'(CAP_T));
  assign load_out = busy_q && (tick_q != last) && (nxt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tick_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      rfw_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (!busy_q) begin
      tick_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      rfw_q  <= 1'b0;
      done_q <= 1'b0;
      if (start) busy_q <= 1'b1;
    end else if (tick_q == last) begin
      busy_q <= 1'b0;
      tick_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      rfw_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      tick_q <= nxt;
      rd_q   <= is_mem && (nxt == CW'(RD_T));
      wr_q   <= is_mem && !is_test && (nxt == CW'(WR_T));
      rfw_q  <= !is_mem && !is_test && (nxt == last);
      done_q <= (nxt == last);
    end
  end

  assign busy      = busy_q;
  assign mem_rd_en = rd_q;
  assign mem_wr_en = wr_q;
  assign rf_wr_en  = rfw_q;
  assign done      = done_q;

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_rfwr_with_done: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> done);
  a_r9_test_no_mem_write: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !is_test);
  a_r9_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));
  a_r8_tick_bound: assert property (@(posedge clk) disable iff (rst)
    tick_q <= CW'(LAST_MEM));
  a_r9_strobes_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en || mem_wr_en) |-> busy_q);
endmodule

// File: rtl/cb_bitop_unit.sv
module cb_bitop_unit
  import cbu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TICKS  = 4,
  parameter int REG_MC = 2,
  parameter int MEM_MC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [3:0]        flags_in,
  input  logic [ADDR_W-1:0] hl_addr,
  output logic [2:0]        rf_rd_sel,
  input  logic [7:0]        rf_rd_data,
  output logic              rf_wr_en,
  output logic [2:0]        rf_wr_sel,
  output logic [7:0]        rf_wr_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [3:0]        flags_out,
  output logic              done
);
  logic [7:0]        opc_q;
  logic [3:0]        fin_q;
  logic [ADDR_W-1:0] hl_q;
  logic [DW-1:0]     opnd_q, data_q, alu_res;
  logic [3:0]        flags_q, alu_flags;
  dec_t              dec;
  logic busy, accept, cap_reg, cap_mem, load_out;

  cbu_decode u_dec (.opc(opc_q), .dec(dec));

  cbu_alu u_alu (
    .dec (dec),
    .a   (opnd_q),
    .fin (fin_q),
    .res (alu_res),
    .fout(alu_flags)
  );

  cbu_ctrl #(.TICKS(TICKS), .REG_MC(REG_MC), .MEM_MC(MEM_MC)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .is_mem   (dec.is_mem),
    .is_test  (dec.is_test),
    .busy     (busy),
    .accept   (accept),
    .cap_reg  (cap_reg),
    .cap_mem  (cap_mem),
    .load_out (load_out),
    .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en),
    .rf_wr_en (rf_wr_en),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q   <= '0;
      fin_q   <= '0;
      hl_q    <= '0;
      opnd_q  <= '0;
      data_q  <= '0;
      flags_q <= '0;
    end else begin
      if (accept) begin
        opc_q <= opcode;
        fin_q <= flags_in;
        hl_q  <= hl_addr;
      end
      if (cap_reg) opnd_q <= rf_rd_data;
      if (cap_mem) opnd_q <= mem_rdata;
      if (busy) data_q <= alu_res;
      if (load_out) flags_q <= alu_flags;
    end
  end

  assign rf_rd_sel  = dec.sel;
  assign rf_wr_sel  = dec.sel;
  assign rf_wr_data = data_q;
  assign mem_wdata  = data_q;
  assign mem_addr   = hl_q;
  assign flags_out  = flags_q;

  a_r11_hold_opcode: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(opc_q));
  a_r7_flags_kept: assert property (@(posedge clk) disable iff (rst)
    (done && (dec.grp == GRP_CLR || dec.grp == GRP_SET)) |-> flags_out == fin_q);
  a_r6_test_no_rf_write: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> !dec.is_test);
  a_r6_test_sets_h: assert property (@(posedge clk) disable iff (rst)
    (done && dec.is_test) |-> (flags_out[FH] && !flags_out[FN]));
endmodule

// File: tb/cb_bitop_unit_tb.sv
module cb_bitop_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {opcode, operand, flags_in, expected result, expected flags ZNHC}
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'h85, 4'b1110, 8'h0B, 4'b0001},  // R2 RLC B
    {8'h09, 8'h01, 4'b1110, 8'h80, 4'b0001},  // R2 RRC C
    {8'h12, 8'h80, 4'b1110, 8'h00, 4'b1001},  // R2 R4 RL D zero
    {8'h1B, 8'h01, 4'b1111, 8'h80, 4'b0001},  // R2 RR E carry in
    {8'h24, 8'hC1, 4'b1110, 8'h82, 4'b0001},  // R3 SLA H
    {8'h2D, 8'h81, 4'b1110, 8'hC0, 4'b0001},  // R3 SRA L
    {8'h37, 8'hF0, 4'b1111, 8'h0F, 4'b0000},  // R5 SWAP A
    {8'h38, 8'h01, 4'b1110, 8'h00, 4'b1001},  // R3 SRL B
    {8'h30, 8'h00, 4'b1111, 8'h00, 4'b1000},  // R5 SWAP zero
    {8'h47, 8'h01, 4'b0001, 8'h01, 4'b0011},  // R6 BIT 0,A
    {8'h7F, 8'h7F, 4'b0100, 8'h7F, 4'b1010},  // R6 BIT 7,A
    {8'h99, 8'hFF, 4'b0101, 8'hF7, 4'b0101},  // R7 RES 3,C
    {8'hE2, 8'h00, 4'b1010, 8'h10, 4'b1010},  // R7 SET 4,D
    {8'h11, 8'h7F, 4'b1111, 8'hFF, 4'b0000}   // R2 RL C
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] opcode = '0;
  logic [3:0] flags_in = '0;
  logic [15:0] hl_addr = '0;
  logic [2:0] rf_rd_sel, rf_wr_sel;
  logic [7:0] rf_rd_data, rf_wr_data, mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic rf_wr_en, mem_rd_en, mem_wr_en, done;
  logic [15:0] mem_addr;
  logic [3:0] flags_out;

  logic [7:0] rf [8];
  logic [7:0] mem [256];
  int n_rfw = 0, n_rd = 0, n_wr = 0, n_done = 0;
  logic [15:0] last_wr_addr = '0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cb_bitop_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .flags_in(flags_in),
    .hl_addr(hl_addr), .rf_rd_sel(rf_rd_sel), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel), .rf_wr_data(rf_wr_data),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .flags_out(flags_out),
    .done(done)
  );

  assign rf_rd_data = rf[rf_rd_sel];

  always @(posedge clk) begin
    if (rf_wr_en) begin rf[rf_wr_sel] <= rf_wr_data; n_rfw <= n_rfw + 1; end
    if (mem_rd_en) begin mem_rdata <= mem[mem_addr[7:0]]; n_rd <= n_rd + 1; end
    if (mem_wr_en) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      last_wr_addr <= mem_addr;
      n_wr <= n_wr + 1;
    end
    if (done) n_done <= n_done + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start one operation and wait for done; returns clocks to done and done width check
  task automatic run_op(input logic [7:0] opc, input logic [3:0] fl, output int ncyc);
    @(negedge clk);
    opcode = opc; flags_in = fl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ncyc = 1;
    while (!done && ncyc < 100) begin
      @(negedge clk);
      ncyc++;
    end
    @(negedge clk);
    chk("R10 done one clock", 32'(done), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nc, w0, r0, d0;
    for (int i = 0; i < 8; i++) rf[i] = 8'h00;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 done", 32'(done), 0);
    chk("R12 rf_wr_en", 32'(rf_wr_en), 0);
    chk("R12 mem_rd_en", 32'(mem_rd_en), 0);
    chk("R12 mem_wr_en", 32'(mem_wr_en), 0);
    chk("R12 flags_out", 32'(flags_out), 0);
    rst = 1'b0;
    @(negedge clk);

    // table of register-operand vectors (R1..R8)
    for (int i = 0; i < NV; i++) begin
      logic [7:0] o, v, e; logic [3:0] f, ef;
      {o, v, f, e, ef} = VEC[i];
      rf[o[2:0]] = v;
      w0 = n_rfw;
      run_op(o, f, nc);
      chk("R8 register op clocks", 32'(nc), 32'd8);
      chk("R1 R2 R3 R5 R7 result", 32'(rf[o[2:0]]), 32'(e));
      chk("R4 R5 R6 R7 flags", 32'(flags_out), 32'(ef));
      chk("R6 R10 writes", 32'(n_rfw - w0), (o[7:6] == 2'b01) ? 32'd0 : 32'd1);
    end

    // R9 memory rotate: read-modify-write at HL
    hl_addr = 16'h1240; mem[8'h40] = 8'h81;
    r0 = n_rd; w0 = n_wr;
    run_op(8'h06, 4'b0110, nc);
    chk("R8 memory op clocks", 32'(nc), 32'd16);
    chk("R9 one read", 32'(n_rd - r0), 1);
    chk("R9 one write", 32'(n_wr - w0), 1);
    chk("R9 write address", 32'(last_wr_addr), 32'h1240);
    chk("R2 memory RLC result", 32'(mem[8'h40]), 32'h03);
    chk("R4 memory RLC flags", 32'(flags_out), 32'b0001);

    // R9 memory bit test: read only
    hl_addr = 16'h0041; mem[8'h41] = 8'h08;
    r0 = n_rd; w0 = n_wr;
    run_op(8'h5E, 4'b0000, nc);
    chk("R8 memory test clocks", 32'(nc), 32'd16);
    chk("R9 test one read", 32'(n_rd - r0), 1);
    chk("R9 test no write", 32'(n_wr - w0), 0);
    chk("R6 memory test flags", 32'(flags_out), 32'b0010);
    chk("R6 memory unchanged", 32'(mem[8'h41]), 32'h08);

    // R7 memory bit set
    hl_addr = 16'h0042; mem[8'h42] = 8'h00;
    run_op(8'hFE, 4'b1001, nc);
    chk("R7 memory set result", 32'(mem[8'h42]), 32'h80);
    chk("R7 memory set flags", 32'(flags_out), 32'b1001);

    // R11 start during an operation is ignored
    rf[0] = 8'h01; rf[1] = 8'h00;
    d0 = n_done;
    @(negedge clk);
    opcode = 8'h00; flags_in = 4'b0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    opcode = 8'hC1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk("R11 single done", 32'(n_done - d0), 1);
    chk("R11 first op result", 32'(rf[0]), 32'h02);
    chk("R11 ignored op no effect", 32'(rf[1]), 32'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule